// File: doc/BRIEF.md
# Code Edge Servo Loop Controller

This block is the digital half of a servo loop that finds converter decision levels. Each time a new converter output code arrives with its valid strobe, the controller compares it with the current search value and drives a single direction bit that tells an external ramp source to climb or fall. Every accepted conversion moves the ramp one step. No averaging happens before a step. Noise rejection comes from a first-order low-pass filter that follows the ramp.

The ramp source is modelled inside the block as a saturating digital accumulator. The filtered accumulator value is the estimate of the lower decision level of the code under test. A sequencer starts at search value 1. After a programmable number of conversions it latches the filtered estimate, raises a one-cycle done pulse and moves on to the next code. It stops once all 2^N - 1 edges of an N-bit converter have been latched.

Top module: `servo_edge_ctrl`

## Requirements
- R1: An accepted conversion whose code is greater than or equal to the search value sets the direction bit to 1 (down) one cycle later and lowers the ramp level by the step size.
- R2: An accepted conversion whose code is below the search value sets the direction bit to 0 (up) one cycle later and raises the ramp level by the step size.
- R3: The ramp level never wraps. It clamps at 0 going down and at 2^ACC_W - 1 going up.
- R4: Each accepted conversion updates the filtered level as filt + ((ramp - filt) >>> shift). The arithmetic shift rounds toward minus infinity, and the ramp value used is the one from before that conversion's step.
- R5: A sweep start pulse sets busy, sets the search value to 1, and clears the ramp, the filter and the settle count in the next cycle. It takes priority over a conversion in the same cycle.
- R6: While busy is low, conversions are ignored: ramp level, filtered level and direction bit hold.
- R7: The cfg_settle-th accepted conversion on an edge is the last one on that edge (0 means 2^CNT_W). One cycle later it gives a one-cycle edge_done pulse. At that pulse edge_level holds the filtered value that includes this conversion, edge_code holds the search value, and the search value has moved up by one.
- R8: A sweep gives exactly 2^CODE_W - 1 done pulses, with edge codes 1, 2, ... in ascending order. Busy clears together with the last pulse.
- R9: After reset, busy, edge_done, the direction bit, ramp level, filtered level, search value, edge code and edge level are all 0.
- R10: When the settle count is long enough for the ramp to reach and track a decision level, the latched edge level lies within 2*step + 2^shift of that level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sweep_start | input | 1 | Pulse that starts a sweep over all edges |
| cfg_step | input | ACC_W | Ramp step magnitude per conversion |
| cfg_shift | input | SH_W | Filter shift K |
| cfg_settle | input | CNT_W | Conversions per edge (0 means 2^CNT_W) |
| adc_valid | input | 1 | New converter code present |
| adc_code | input | CODE_W | Converter output code |
| ramp_dn | output | 1 | Direction bit: 1 ramp down, 0 ramp up |
| ramp_level | output | ACC_W | Modelled ramp accumulator value |
| filt_level | output | ACC_W | Low-pass filtered ramp value |
| busy | output | 1 | Sweep in progress |
| search_code | output | CODE_W | Current search value |
| edge_done | output | 1 | One-cycle pulse when an edge is latched |
| edge_code | output | CODE_W | Code whose lower edge was latched |
| edge_level | output | ACC_W | Latched filtered edge estimate |

## Verification
The loop is closed through a noise-free quantizer in the bench. Its fifteen decision levels have uneven spacing, so the estimates cannot all be right by chance. It runs once with a fine step and heavy filtering, and again with a coarse step, a light filter and a shorter settle count. These runs separate correct direction choices and filter arithmetic from near misses, and show that convergence is correct at each edge and not only on average. Hand-fed constant-low and constant-high code runs with a large step drive the ramp into both rails to expose wrap-around. Conversions fed while idle, and a start pulse that coincides with a conversion, check that nothing is accepted outside a sweep.

// File: rtl/servo_pkg.sv
package servo_pkg;
    typedef enum logic {
        DIR_UP = 1'b0,
        DIR_DN = 1'b1
    } dir_e;

    function automatic dir_e pick_dir(input int unsigned code, input int unsigned target);
        return (code >= target) ? DIR_DN : DIR_UP;
    endfunction
endpackage

// File: rtl/servo_ramp.sv
module servo_ramp
    import servo_pkg::*;
#(
    parameter int ACC_W  = 16,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              en,
    input  logic [CODE_W-1:0] code,
    input  logic [CODE_W-1:0] target,
    input  logic [ACC_W-1:0]  step,
    output logic [ACC_W-1:0]  level_q,
    output logic              dir_q
);
    localparam logic [ACC_W-1:0] LVL_MAX = {ACC_W{1'b1}};

    dir_e              dir_n;
    logic [ACC_W:0]    up_sum;
    logic [ACC_W-1:0]  up_val;
    logic [ACC_W-1:0]  dn_val;

    always_comb begin
        dir_n  = pick_dir(int'(code), int'(target));
        up_sum = {1'b0, level_q} + {1'b0, step};
        up_val = up_sum[ACC_W] ? LVL_MAX : up_sum[ACC_W-1:0];
        dn_val = (level_q < step) ? '0 : level_q - step;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            level_q <= '0;
            dir_q   <= 1'b0;
        end else if (en) begin
            level_q <= (dir_n == DIR_DN) ? dn_val : up_val;
            dir_q   <= (dir_n == DIR_DN);
        end
    end
endmodule

// File: rtl/servo_iir.sv
module servo_iir #(
    parameter int ACC_W = 16,
    parameter int SH_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [ACC_W-1:0] x,
    input  logic [SH_W-1:0]  shift,
    output logic [ACC_W-1:0] y_q,
    output logic [ACC_W-1:0] y_next
);
    localparam int EXT_W = ACC_W + 2;

    logic signed [EXT_W-1:0] diff;
    logic signed [EXT_W-1:0] delta;
    logic signed [EXT_W-1:0] sum;

    always_comb begin
        diff   = $signed({2'b00, x}) - $signed({2'b00, y_q});
        delta  = diff >>> shift;
        sum    = $signed({2'b00, y_q}) + delta;
        y_next = sum[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || clr) y_q <= '0;
        else if (en)    y_q <= y_next;
    end
endmodule

// File: rtl/servo_seq.sv
module servo_seq #(
    parameter int CODE_W = 4,
    parameter int CNT_W  = 10,
    parameter int ACC_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              accept,
    input  logic [CNT_W-1:0]  settle,
    input  logic [ACC_W-1:0]  lvl_in,
    output logic              busy_q,
    output logic [CODE_W-1:0] target_q,
    output logic              done_q,
    output logic [CODE_W-1:0] ecode_q,
    output logic [ACC_W-1:0]  elevel_q
);
    localparam logic [CODE_W-1:0] LAST_CODE = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] FIRST_CODE = CODE_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_lim;
    logic             last_conv;

    always_comb begin
        cnt_lim   = settle - 1'b1;
        last_conv = accept && (cnt_q == cnt_lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            target_q <= '0;
            cnt_q    <= '0;
            done_q   <= 1'b0;
            ecode_q  <= '0;
            elevel_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                busy_q   <= 1'b1;
                target_q <= FIRST_CODE;
                cnt_q    <= '0;
            end else if (last_conv) begin
                done_q   <= 1'b1;
                ecode_q  <= target_q;
                elevel_q <= lvl_in;
                cnt_q    <= '0;
                target_q <= target_q + 1'b1;
                if (target_q == LAST_CODE) busy_q <= 1'b0;
            end else if (accept) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/servo_edge_ctrl.sv
module servo_edge_ctrl #(
    parameter int CODE_W = 4,
    parameter int ACC_W  = 16,
    parameter int CNT_W  = 10,
    parameter int SH_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sweep_start,
    input  logic [ACC_W-1:0]  cfg_step,
    input  logic [SH_W-1:0]   cfg_shift,
    input  logic [CNT_W-1:0]  cfg_settle,
    input  logic              adc_valid,
    input  logic [CODE_W-1:0] adc_code,
    output logic              ramp_dn,
    output logic [ACC_W-1:0]  ramp_level,
    output logic [ACC_W-1:0]  filt_level,
    output logic              busy,
    output logic [CODE_W-1:0] search_code,
    output logic              edge_done,
    output logic [CODE_W-1:0] edge_code,
    output logic [ACC_W-1:0]  edge_level
);
    logic             accept;
    logic [ACC_W-1:0] filt_next;

    assign accept = adc_valid && busy && !sweep_start;

    servo_ramp #(.ACC_W(ACC_W), .CODE_W(CODE_W)) u_ramp (
        .clk(clk), .rst(rst), .clr(sweep_start), .en(accept),
        .code(adc_code), .target(search_code), .step(cfg_step),
        .level_q(ramp_level), .dir_q(ramp_dn)
    );

    servo_iir #(.ACC_W(ACC_W), .SH_W(SH_W)) u_iir (
        .clk(clk), .rst(rst), .clr(sweep_start), .en(accept),
        .x(ramp_level), .shift(cfg_shift),
        .y_q(filt_level), .y_next(filt_next)
    );

    servo_seq #(.CODE_W(CODE_W), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_seq (
        .clk(clk), .rst(rst), .start(sweep_start), .accept(accept),
        .settle(cfg_settle), .lvl_in(filt_next),
        .busy_q(busy), .target_q(search_code),
        .done_q(edge_done), .ecode_q(edge_code), .elevel_q(edge_level)
    );
endmodule

// File: rtl/servo_edge_chk.sv
module servo_edge_chk #(
    parameter int CODE_W = 4,
    parameter int ACC_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              sweep_start,
    input logic [ACC_W-1:0]  cfg_step,
    input logic              adc_valid,
    input logic [CODE_W-1:0] adc_code,
    input logic              ramp_dn,
    input logic [ACC_W-1:0]  ramp_level,
    input logic [ACC_W-1:0]  filt_level,
    input logic              busy,
    input logic [CODE_W-1:0] search_code,
    input logic              edge_done,
    input logic [CODE_W-1:0] edge_code
);
    localparam logic [ACC_W-1:0] TOP = {ACC_W{1'b1}};
    logic take;
    logic [ACC_W-1:0] headroom;
    assign take = busy && adc_valid && !sweep_start;
    assign headroom = TOP - cfg_step;

    assert_dir_down_R1: assert property (@(posedge clk) disable iff (rst)
        (take && adc_code >= search_code) |=> (ramp_dn && ramp_level <= $past(ramp_level)));

    assert_dir_up_R2: assert property (@(posedge clk) disable iff (rst)
        (take && adc_code < search_code) |=> (!ramp_dn && ramp_level >= $past(ramp_level)));

    assert_clamp_top_R3: assert property (@(posedge clk) disable iff (rst)
        (take && adc_code < search_code && ramp_level > headroom) |=> (ramp_level == TOP));

    assert_start_init_R5: assert property (@(posedge clk) disable iff (rst)
        sweep_start |=> (busy && search_code == CODE_W'(1) && ramp_level == '0 && filt_level == '0));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy && !sweep_start) |=> ($stable(ramp_level) && $stable(filt_level) && $stable(ramp_dn)));

    assert_done_cause_R7: assert property (@(posedge clk) disable iff (rst)
        edge_done |-> $past(take));

    assert_code_order_R8: assert property (@(posedge clk) disable iff (rst)
        edge_done |-> (edge_code == CODE_W'(search_code - 1'b1)));

    assert_end_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (edge_done && edge_code == {CODE_W{1'b1}}) |-> !busy);
endmodule

bind servo_edge_ctrl servo_edge_chk #(.CODE_W(CODE_W), .ACC_W(ACC_W)) u_chk (
    .clk(clk), .rst(rst), .sweep_start(sweep_start), .cfg_step(cfg_step),
    .adc_valid(adc_valid), .adc_code(adc_code), .ramp_dn(ramp_dn),
    .ramp_level(ramp_level), .filt_level(filt_level), .busy(busy),
    .search_code(search_code), .edge_done(edge_done), .edge_code(edge_code)
);

// File: tb/sim_servo_edge_ctrl.sv
module sim_servo_edge_ctrl;
    localparam int CODE_W = 4;
    localparam int ACC_W  = 16;
    localparam int CNT_W  = 10;
    localparam int SH_W   = 4;
    localparam int NEDGE  = (1 << CODE_W) - 1;
    localparam int LMAX   = (1 << ACC_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sweep_start = 1'b0;
    logic [ACC_W-1:0] cfg_step = '0;
    logic [SH_W-1:0] cfg_shift = '0;
    logic [CNT_W-1:0] cfg_settle = '0;
    logic adc_valid = 1'b0;
    logic [CODE_W-1:0] adc_code = '0;
    logic ramp_dn, busy, edge_done;
    logic [ACC_W-1:0] ramp_level, filt_level, edge_level;
    logic [CODE_W-1:0] search_code, edge_code;

    always #2.5 clk = ~clk;

    servo_edge_ctrl #(.CODE_W(CODE_W), .ACC_W(ACC_W), .CNT_W(CNT_W), .SH_W(SH_W)) u0 (
        .clk(clk), .rst(rst), .sweep_start(sweep_start), .cfg_step(cfg_step),
        .cfg_shift(cfg_shift), .cfg_settle(cfg_settle), .adc_valid(adc_valid),
        .adc_code(adc_code), .ramp_dn(ramp_dn), .ramp_level(ramp_level),
        .filt_level(filt_level), .busy(busy), .search_code(search_code),
        .edge_done(edge_done), .edge_code(edge_code), .edge_level(edge_level)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int m_ramp, m_filt, m_tgt, m_cnt, m_dn, m_busy;
    int m_step, m_shift, m_settle;
    int x_done, x_code, x_lvl;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int thr(input int i);
        return i * 4096 + ((i * 37) % 11) * 50;
    endfunction

    function automatic int quant(input int lvl);
        int c = 0;
        for (int i = 1; i <= NEDGE; i++) if (lvl >= thr(i)) c++;
        return c;
    endfunction

    task automatic cfg(input int step, input int sh, input int settle);
        cfg_step = ACC_W'(step); cfg_shift = SH_W'(sh); cfg_settle = CNT_W'(settle);
        m_step = step; m_shift = sh;
        m_settle = (settle == 0) ? (1 << CNT_W) : settle;
    endtask

    // one conversion; entered and left at a falling edge
    task automatic conv(input int code);
        int nf, nr;
        adc_code = CODE_W'(code);
        adc_valid = 1'b1;
        x_done = 0;
        if (m_busy != 0) begin
            m_dn = (code >= m_tgt) ? 1 : 0;
            nf = m_filt + ((m_ramp - m_filt) >>> m_shift);
            if (m_dn != 0) nr = (m_ramp < m_step) ? 0 : m_ramp - m_step;
            else           nr = (m_ramp + m_step > LMAX) ? LMAX : m_ramp + m_step;
            m_cnt++;
            if (m_cnt == m_settle) begin
                x_done = 1; x_code = m_tgt; x_lvl = nf; m_cnt = 0;
                m_tgt = (m_tgt + 1) % (NEDGE + 1);
                if (m_tgt == 0) m_busy = 0;
            end
            m_ramp = nr; m_filt = nf;
        end
        @(posedge clk); @(negedge clk);
        adc_valid = 1'b0;
        chk(int'(ramp_level) == m_ramp, (m_dn != 0) ? "R1" : "R2", "ramp", ramp_level, m_ramp);
        chk(int'(ramp_dn) == m_dn, (m_dn != 0) ? "R1" : "R2", "dir", ramp_dn, m_dn);
        chk(int'(filt_level) == m_filt, "R4", "filt", filt_level, m_filt);
        chk(int'(edge_done) == x_done, "R7", "done", edge_done, x_done);
        chk(int'(busy) == m_busy, "R8", "busy", busy, m_busy);
        if (x_done != 0) begin
            chk(int'(edge_code) == x_code, "R8", "edge_code", edge_code, x_code);
            chk(int'(edge_level) == x_lvl, "R7", "edge_level", edge_level, x_lvl);
            chk(int'(search_code) == m_tgt, "R7", "search", search_code, m_tgt);
        end
    endtask

    task automatic start_sweep(input int code_during);
        sweep_start = 1'b1;
        adc_valid = 1'b1;
        adc_code = CODE_W'(code_during);
        @(posedge clk); @(negedge clk);
        sweep_start = 1'b0;
        adc_valid = 1'b0;
        m_ramp = 0; m_filt = 0; m_tgt = 1; m_cnt = 0; m_dn = 0; m_busy = 1;
        chk(busy == 1'b1, "R5", "busy", busy, 1);
        chk(int'(search_code) == 1, "R5", "search", search_code, 1);
        chk(ramp_level == '0, "R5", "ramp", ramp_level, 0);
        chk(filt_level == '0, "R5", "filt", filt_level, 0);
    endtask

    task automatic sweep(input int step, input int sh, input int settle);
        int ndone = 0;
        int expect_code = 1;
        int tol = 2 * step + (1 << sh);
        cfg(step, sh, settle);
        start_sweep(0);
        while (m_busy != 0) begin
            conv(quant(int'(ramp_level)));
            if (x_done != 0) begin
                int err = int'(edge_level) - thr(x_code);
                if (err < 0) err = -err;
                chk(err <= tol, "R10", "edge error", err, tol);
                chk(x_code == expect_code, "R8", "order", x_code, expect_code);
                expect_code++;
                ndone++;
            end
        end
        chk(ndone == NEDGE, "R8", "pulse count", ndone, NEDGE);
        chk(busy == 1'b0, "R8", "busy end", busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=expired expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_ramp = 0; m_filt = 0; m_tgt = 0; m_cnt = 0; m_dn = 0; m_busy = 0;
        cfg(100, 0, 4);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        chk(busy == 1'b0 && edge_done == 1'b0 && ramp_dn == 1'b0, "R9", "flags", {busy, edge_done, ramp_dn}, 0);
        chk(ramp_level == '0 && filt_level == '0, "R9", "levels", ramp_level, 0);
        chk(search_code == '0 && edge_code == '0 && edge_level == '0, "R9", "codes", search_code, 0);
        // R6 idle conversions ignored
        conv(5); conv(0); conv(15);
        chk(ramp_level == '0 && filt_level == '0, "R6", "idle hold", ramp_level, 0);
        // R3 saturation both rails, shift 0 so filter follows prior ramp
        cfg(16'h7000, 0, 0);
        start_sweep(0);
        for (int i = 0; i < 4; i++) conv(0);
        chk(int'(ramp_level) == LMAX, "R3", "top clamp", ramp_level, LMAX);
        for (int i = 0; i < 4; i++) conv(15);
        chk(ramp_level == '0, "R3", "bottom clamp", ramp_level, 0);
        conv(0);
        // R5 restart during busy with coincident conversion
        start_sweep(0);
        // R7 settle of 1 latches every conversion
        cfg(300, 1, 1);
        for (int i = 0; i < 3; i++) conv(0);
        // full closed-loop sweeps
        sweep(64, 4, 256);
        sweep(200, 2, 100);
        // R6 after sweep end
        conv(0); conv(15);
        chk(busy == 1'b0, "R6", "idle after sweep", busy, 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule